// File: doc/BRIEF.md
# Destructive-Readout Memory Controller

This controller sits between a processor and a word store made of two equal banks. Each bank behaves like magnetic core: sensing a location clears it. The processor issues single-word read or write requests with an in-bank address. A separate bank-select input works like a static switch and chooses the bank that the request addresses. The controller captures the select at the moment it accepts a request.

A read runs in two phases. In the sense phase the word is copied into a buffer register and the location is cleared. In the restore phase the buffer contents are written back. The word is then handed to the processor from the buffer. A write needs only one phase and stores its data directly. While a cycle is running the controller holds `busy` high and ignores new requests.

The production configuration sets `ADDR_W` to 13. That gives two 8192-word banks, 16,384 words of 16 bits in total. The default of 10 keeps elaboration small and behaves the same way.

Top module: `drom_ctrl`

## Requirements
- R1: The store holds two banks of 2^ADDR_W words of 16 bits each. `bank_sel` = 0 addresses bank 0 and `bank_sel` = 1 addresses bank 1. The same `req_addr` in the two banks names two independent words, including the highest address (all ones).
- R2: A read is accepted on a rising edge where `req_valid` = 1, `req_write` = 0 and `busy` = 0. After the second rising edge that follows acceptance, `rd_valid` is 1 for exactly one cycle and `rd_data` equals the word stored at that location.
- R3: A read clears the location during sensing and writes the buffered word back during restore. Reading the same location again returns the same word.
- R4: `rd_data` shows the buffer register. It keeps the last word read until another read completes, and writes leave it unchanged.
- R5: A write is accepted with `req_write` = 1 and keeps `busy` high for one cycle. It replaces the stored word with `req_wdata`, and a later read returns the new word.
- R6: A read keeps `busy` high for the two cycles after acceptance and low in the cycle after that. After reset, `busy` = 0, `rd_valid` = 0 and `rd_data` = 0.
- R7: A request presented while `busy` = 1 is ignored. It writes nothing and starts no cycle.
- R8: `bank_sel` is sampled only when a request is accepted. Changing it during a cycle does not change the bank that the cycle reads, restores or writes.
- R9: A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | In-bank word address |
| req_wdata | input | 16 | Write data |
| bank_sel | input | 1 | Bank switch, sampled at acceptance |
| busy | output | 1 | Cycle in progress |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 16 | Buffer register contents |

## Verification
The bench reads the same location twice. A controller that skipped or misdirected the restore would return zero on the second read. It presents writes while a read is still in progress and then reads the targeted words back. Acting on such a request would corrupt them or extend the cycle. It flips the bank switch in the middle of reads and writes. A controller that followed the live switch would restore the word into the other bank or write the wrong bank, and the read-backs from both banks would show it. It also reads the top address in both banks and checks that `rd_data` keeps its value across writes.

// File: rtl/drom_pkg.sv
package drom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SENSE   = 2'd1,
    ST_RESTORE = 2'd2,
    ST_WRITE   = 2'd3
  } drom_state_e;

  // number of busy cycles an accepted request occupies
  function automatic int unsigned busy_len(input logic is_write);
    return is_write ? 1 : 2;
  endfunction

  // state entered when a request is accepted
  function automatic drom_state_e first_phase(input logic is_write);
    return is_write ? ST_WRITE : ST_SENSE;
  endfunction

  // state following the current one
  function automatic drom_state_e next_phase(input drom_state_e cur);
    case (cur)
      ST_SENSE: return ST_RESTORE;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/drom_bank.sv
module drom_bank #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              sense_en,
  input  logic              store_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] store_data,
  output logic [WORD_W-1:0] sense_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  // the sensed word is visible during the sense phase
  assign sense_data = cells[addr];

  // sensing destroys the word; a store writes a full word
  always_ff @(posedge clk) begin
    if (sense_en)
      cells[addr] <= '0;
    else if (store_en)
      cells[addr] <= store_data;
  end
endmodule

// File: rtl/drom_seq.sv
module drom_seq
  import drom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        accept,
  output logic        busy,
  output logic        sense_fire,
  output logic        restore_fire,
  output logic        write_fire
);
  drom_state_e state_q;

  assign busy         = (state_q != ST_IDLE);
  assign accept       = req_valid && (state_q == ST_IDLE);
  assign sense_fire   = (state_q == ST_SENSE);
  assign restore_fire = (state_q == ST_RESTORE);
  assign write_fire   = (state_q == ST_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else if (accept)
      state_q <= first_phase(req_write);
    else
      state_q <= next_phase(state_q);
  end
endmodule

// File: rtl/drom_ctrl.sv
module drom_ctrl #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16,
  parameter int NBANK  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        req_wdata,
  input  logic [$clog2(NBANK)-1:0] bank_sel,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [WORD_W-1:0]        rd_data
);
  localparam int SEL_W = $clog2(NBANK);

  // internal events, named for the checker
  logic accept;
  logic sense_fire;
  logic restore_fire;
  logic write_fire;

  logic [ADDR_W-1:0] cyc_addr;
  logic [SEL_W-1:0]  cyc_bank;
  logic [WORD_W-1:0] cyc_wdata;
  logic [WORD_W-1:0] rd_buf;
  logic [WORD_W-1:0] store_word;
  logic [WORD_W-1:0] bank_rdata [NBANK];

  drom_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .accept       (accept),
    .busy         (busy),
    .sense_fire   (sense_fire),
    .restore_fire (restore_fire),
    .write_fire   (write_fire)
  );

  // request fields, including the bank switch, are frozen at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_addr  <= '0;
      cyc_bank  <= '0;
      cyc_wdata <= '0;
    end else if (accept) begin
      cyc_addr  <= req_addr;
      cyc_bank  <= bank_sel;
      cyc_wdata <= req_wdata;
    end
  end

  assign store_word = restore_fire ? rd_buf : cyc_wdata;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = (cyc_bank == SEL_W'(g));
    drom_bank #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
    ) u_bank (
      .clk        (clk),
      .sense_en   (sense_fire && hit),
      .store_en   ((restore_fire || write_fire) && hit),
      .addr       (cyc_addr),
      .store_data (store_word),
      .sense_data (bank_rdata[g])
    );
  end

  // buffer register: captured while sensing, drives restore and the output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_buf   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (sense_fire)
        rd_buf <= bank_rdata[cyc_bank];
      rd_valid <= restore_fire;
    end
  end

  assign rd_data = rd_buf;
endmodule

// File: rtl/drom_checker.sv
module drom_checker #(
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rd_valid,
  input logic             accept,
  input logic             sense_fire,
  input logic             restore_fire,
  input logic             write_fire,
  input logic [SEL_W-1:0] cyc_bank
);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_sense_then_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sense_fire |=> restore_fire);

  p_restore_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restore_fire |=> (!busy && rd_valid));

  p_write_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> !busy);

  p_write_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> !rd_valid);

  p_valid_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(restore_fire));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_fire && $past(sense_fire)) |-> 1'b0);

  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cyc_bank));

  p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sense_fire, restore_fire, write_fire}));
endmodule

bind drom_ctrl drom_checker #(.SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rd_valid     (rd_valid),
  .accept       (accept),
  .sense_fire   (sense_fire),
  .restore_fire (restore_fire),
  .write_fire   (write_fire),
  .cyc_bank     (cyc_bank)
);

// File: tb/drom_ctrl_bench.sv
module drom_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NV = 12;

  // {is_write, bank, addr, data}; for reads data is the expected word
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 10'd5,     16'h1234},
    {1'b1, 1'b1, 10'd5,     16'hABCD},
    {1'b1, 1'b0, 10'd0,     16'h0001},
    {1'b1, 1'b1, 10'h3FF,   16'hFFFF},
    {1'b0, 1'b0, 10'd5,     16'h1234},
    {1'b0, 1'b1, 10'd5,     16'hABCD},
    {1'b0, 1'b0, 10'd5,     16'h1234},
    {1'b0, 1'b0, 10'd0,     16'h0001},
    {1'b0, 1'b1, 10'h3FF,   16'hFFFF},
    {1'b1, 1'b0, 10'd5,     16'h5A5A},
    {1'b0, 1'b0, 10'd5,     16'h5A5A},
    {1'b0, 1'b1, 10'd5,     16'hABCD}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          bank_sel = 1'b0;
  logic          busy;
  logic          rd_valid;
  logic [15:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drom_ctrl #(.ADDR_W(AW)) u_drom_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bank_sel  (bank_sel),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mid_sel: value driven on bank_sel one cycle after the request
  task automatic do_read(input logic b, input logic [AW-1:0] a,
                         input logic [15:0] exp, input logic mid_sel, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; bank_sel = b; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; bank_sel = mid_sel;
    chk({tag, " R6 busy phase1"}, 16'(busy), 16'd1);
    @(negedge clk);
    chk({tag, " R6 busy phase2"}, 16'(busy), 16'd1);
    chk({tag, " R2 no early valid"}, 16'(rd_valid), 16'd0);
    @(negedge clk);
    chk({tag, " R6 idle after read"}, 16'(busy), 16'd0);
    chk({tag, " R2 valid pulse"}, 16'(rd_valid), 16'd1);
    chk({tag, " R2 data"}, rd_data, exp);
  endtask

  task automatic do_write(input logic b, input logic [AW-1:0] a,
                          input logic [15:0] d, input logic mid_sel, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; bank_sel = b; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; bank_sel = mid_sel;
    chk({tag, " R5 busy one cycle"}, 16'(busy), 16'd1);
    chk({tag, " R9 no valid"}, 16'(rd_valid), 16'd0);
    @(negedge clk);
    chk({tag, " R5 idle after write"}, 16'(busy), 16'd0);
    chk({tag, " R9 no valid end"}, 16'(rd_valid), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset busy", 16'(busy), 16'd0);
    chk("R6 reset valid", 16'(rd_valid), 16'd0);
    chk("R6 reset data", rd_data, 16'd0);

    // R1 R2 R3 R5: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27])
        do_write(VEC[i][26], VEC[i][25:16], VEC[i][15:0], VEC[i][26], $sformatf("vec%0d R1", i));
      else
        do_read(VEC[i][26], VEC[i][25:16], VEC[i][15:0], VEC[i][26], $sformatf("vec%0d R3", i));
    end

    // R4: a write leaves the buffer untouched
    do_write(1'b0, 10'd7, 16'h1111, 1'b0, "r4 wr");
    @(negedge clk);
    chk("R4 buffer held over write", rd_data, 16'hABCD);

    // R7: requests during a read are ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; bank_sel = 1'b0; req_addr = 10'd5;
    @(negedge clk);
    req_write = 1'b1; req_addr = 10'd7; req_wdata = 16'h0000;
    chk("R7 busy", 16'(busy), 16'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 still busy", 16'(busy), 16'd1);
    @(negedge clk);
    chk("R7 read done", rd_data, 16'h5A5A);
    chk("R7 no extra cycle", 16'(busy), 16'd0);
    do_read(1'b0, 10'd7, 16'h1111, 1'b0, "r7 target kept");
    do_read(1'b0, 10'd5, 16'h5A5A, 1'b0, "r7 read loc kept");

    // R8: switch flips mid-read
    do_read(1'b1, 10'd5, 16'hABCD, 1'b0, "r8 flip read");
    do_read(1'b0, 10'd5, 16'h5A5A, 1'b0, "r8 other bank");
    do_read(1'b1, 10'd5, 16'hABCD, 1'b1, "r8 restored bank");

    // R8: switch flips mid-write
    do_write(1'b0, 10'd3, 16'h0303, 1'b0, "r8 wr b0");
    do_write(1'b1, 10'd3, 16'h3131, 1'b0, "r8 flip write");
    do_read(1'b0, 10'd3, 16'h0303, 1'b0, "r8 b0 intact");
    do_read(1'b1, 10'd3, 16'h3131, 1'b1, "r8 b1 written");

    // R1: top address in bank 1 still intact, bank 0 top distinct
    do_write(1'b0, 10'h3FF, 16'h0F0F, 1'b0, "r1 top b0");
    do_read(1'b1, 10'h3FF, 16'hFFFF, 1'b1, "r1 top b1");
    do_read(1'b0, 10'h3FF, 16'h0F0F, 1'b0, "r1 top b0");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule